// File: doc/BRIEF.md
# Decode-Stage Return Verifier Stack

This block sits in the decode stage and checks the return targets that the front-end predictor guessed. Every decoded call pushes the address of the instruction after it onto a 16-entry circular stack. When a return is decoded, the block compares the front end's predicted target with its own top entry. If the two differ, the next cycle carries a one-cycle resteer pulse with the correct address. In that same cycle the block's whole stack state (entries, top pointer and occupancy) is offered to the front-end predictor stack so that it can overwrite its own copy. An empty stack never overrides the front end.

Two recovery paths keep the stack in step with the real program. First, each verified branch gets a tag holding the current top pointer, the current occupancy and its fall-through address. When that branch later turns out to be mispredicted at execute, the tag is handed back and the pointer and occupancy are restored from it. Second, a retirement-side architectural stack is updated only by retiring calls and returns. On any pipeline flush, interrupts included, that stack is copied into this stack and offered to the predictor stack.

A small Moore state machine produces the pulses. `ST_RUN` is the quiet state. The transition RUN/RESTEER/RELOAD→`ST_RESTEER` is taken on a decoded return that mismatches a non-empty stack, and it drives the resteer and copy pulses. The transition any→`ST_RELOAD` is taken on a flush, and it drives the copy pulse alone. The transition any→`ST_RUN` is taken in every other cycle.

Top module: `ret_verify_stack`

## Requirements
- R1: After reset the top pointer and the occupancy are 0. A decoded call (when no flush or restore happens in the same cycle) advances the pointer by one, modulo 16, writes the call's next address into the slot the pointer now names, and raises the occupancy by one, up to a maximum of 16.
- R2: A decoded return on a non-empty stack pops it: the pointer goes down by one modulo 16 and the occupancy by one. If the predicted target differs from the top entry before the pop, `resteer_o` is high for exactly the next cycle and `resteer_addr_o` holds that top entry. If the prediction matches, no pulse is produced.
- R3: A mismatch also raises `pred_copy_o` in the same cycle as `resteer_o`. During that cycle the state outputs show the stack after the pop.
- R4: A decoded return on an empty stack changes nothing: there is no pop, no resteer and no copy pulse.
- R5: A cycle with `dec_br_i` high produces, in the next cycle, a one-cycle `tag_vld_o`. The tag carries the pointer and occupancy as they stood before that cycle's update, together with `dec_fall_i`.
- R6: An execute misprediction (without a flush) loads the pointer and occupancy from `exe_ptr_i`/`exe_cnt_i`. The entries are left as they are, and a call or return decoded in that cycle is discarded.
- R7: The architectural stack is pushed by retiring calls and popped by retiring returns under the same circular rules. A flush copies its state as it was before the cycle into this stack. In the next cycle `pred_copy_o` is high and `resteer_o` is low. A flush outranks a restore and any decode in the same cycle.
- R8: If a call and a return are decoded in the same cycle, only the call is performed and the return is ignored.
- R9: After more than 16 calls the oldest entries have been overwritten. Returns then verify against the 16 most recent call addresses, newest first, and after that the stack reads as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_call_i | input | 1 | Call decoded this cycle |
| dec_ret_i | input | 1 | Return decoded this cycle |
| dec_nla_i | input | AW | Next address of the decoded call |
| dec_pred_i | input | AW | Front-end predicted target of the decoded return |
| dec_br_i | input | 1 | Branch verified this cycle, tag requested |
| dec_fall_i | input | AW | Fall-through address of that branch |
| exe_mispred_i | input | 1 | Execute-stage misprediction, restore from tag |
| exe_ptr_i | input | PW | Pointer from the mispredicted branch's tag |
| exe_cnt_i | input | CW | Occupancy from the mispredicted branch's tag |
| flush_i | input | 1 | Pipeline flush, reload from architectural stack |
| rt_call_i | input | 1 | Call retired |
| rt_ret_i | input | 1 | Return retired |
| rt_nla_i | input | AW | Next address of the retired call |
| resteer_o | output | 1 | Clear-and-resteer pulse |
| resteer_addr_o | output | AW | Corrected return target |
| pred_copy_o | output | 1 | Predictor stack must take the state below |
| pred_ptr_o | output | PW | Current top pointer |
| pred_cnt_o | output | CW | Current occupancy |
| pred_ent_o | output | DEPTH*AW | All entries, slot e at bits e*AW upward |
| tag_vld_o | output | 1 | Tag valid pulse |
| tag_ptr_o | output | PW | Tagged pointer |
| tag_cnt_o | output | CW | Tagged occupancy |
| tag_fall_o | output | AW | Tagged fall-through address |

## Verification
The main sweep pushes every call count from 0 to 20 and then decodes more returns than there are entries. The predictions alternate between wrong and right. A wrong prediction must give a resteer carrying the exact pushed address, while a right one must stay silent. This separates correct comparison from a stuck or inverted pulse, and runs past 16 shows overwrite-oldest apart from refusing pushes. The returns beyond the occupancy separate "empty means no override" from a wrap that goes on comparing. Directed sequences then collide a restore with a decoded call, a flush with a restore and a return, and a call with a return. Each of these exposes a wrong priority order.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RESTEER = 2'd1,
        ST_RELOAD  = 2'd2
    } rvs_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } rvs_op_e;

endpackage

// File: rtl/rvs_lifo.sv
module rvs_lifo
    import rvs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rvs_op_e             op_i,
    input  logic [AW-1:0]       push_addr_i,
    input  logic                ld_state_i,
    input  logic                ld_mem_i,
    input  logic [PW-1:0]       ld_ptr_i,
    input  logic [CW-1:0]       ld_cnt_i,
    input  logic [DEPTH*AW-1:0] ld_ent_i,
    output logic [PW-1:0]       ptr_o,
    output logic [CW-1:0]       cnt_o,
    output logic [DEPTH*AW-1:0] ent_o
);

    logic [PW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          full, empty;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign ptr_inc = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    assign ptr_dec = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;

    // Pointer/occupancy next state: load outranks any push or pop.
    always_comb begin
        ptr_d = ptr_q;
        cnt_d = cnt_q;
        if (ld_state_i) begin
            ptr_d = ld_ptr_i;
            cnt_d = ld_cnt_i;
        end else begin
            unique case (op_i)
                OP_PUSH: begin
                    ptr_d = ptr_inc;
                    cnt_d = full ? cnt_q : cnt_q + 1'b1;
                end
                OP_POP: begin
                    if (!empty) begin
                        ptr_d = ptr_dec;
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
        end
    end

    // One register per slot; a push writes the slot after the current top.
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic [AW-1:0] val_q;
        logic          wr;
        assign wr = !ld_state_i && (op_i == OP_PUSH) && (ptr_inc == PW'(e));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (ld_mem_i)
                val_q <= ld_ent_i[e*AW +: AW];
            else if (wr)
                val_q <= push_addr_i;
        end
        assign ent_o[e*AW +: AW] = val_q;
    end

    assign ptr_o = ptr_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/rvs_ctrl.sv
module rvs_ctrl
    import rvs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          mispred_i,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic [AW-1:0] pred_i,
    input  logic [AW-1:0] top_i,
    input  logic          empty_i,
    output rvs_op_e       op_o,
    output logic          ld_state_o,
    output logic          ld_mem_o,
    output logic          resteer_o,
    output logic [AW-1:0] resteer_addr_o,
    output logic          copy_o
);

    rvs_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          squash, take_call, take_ret, miss;

    // Decode qualification: flush and restore squash decode; call beats return.
    assign squash    = flush_i || mispred_i;
    assign take_call = call_i && !squash;
    assign take_ret  = ret_i && !call_i && !squash;
    assign miss      = take_ret && !empty_i && (pred_i != top_i);

    always_comb begin
        if (take_call)
            op_o = OP_PUSH;
        else if (take_ret)
            op_o = OP_POP;
        else
            op_o = OP_NONE;
    end

    assign ld_state_o = squash;
    assign ld_mem_o   = flush_i;

    // Next-state logic.
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_RESTEER, ST_RELOAD: begin
                if (flush_i)
                    state_d = ST_RELOAD;
                else if (miss)
                    state_d = ST_RESTEER;
                else
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (miss)
            addr_q <= top_i;
    end

    // Moore outputs.
    always_comb begin
        resteer_o = 1'b0;
        copy_o    = 1'b0;
        unique case (state_q)
            ST_RESTEER: begin
                resteer_o = 1'b1;
                copy_o    = 1'b1;
            end
            ST_RELOAD: copy_o = 1'b1;
            default: ;
        endcase
    end

    assign resteer_addr_o = addr_q;

endmodule

// File: rtl/rvs_tag.sv
module rvs_tag #(
    parameter int AW = 32,
    parameter int PW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_i,
    input  logic [AW-1:0] fall_i,
    input  logic [PW-1:0] ptr_i,
    input  logic [CW-1:0] cnt_i,
    output logic          vld_o,
    output logic [PW-1:0] ptr_o,
    output logic [CW-1:0] cnt_o,
    output logic [AW-1:0] fall_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            ptr_o  <= '0;
            cnt_o  <= '0;
            fall_o <= '0;
        end else begin
            vld_o <= br_i;
            if (br_i) begin
                ptr_o  <= ptr_i;
                cnt_o  <= cnt_i;
                fall_o <= fall_i;
            end
        end
    end

endmodule

// File: rtl/ret_verify_stack.sv
module ret_verify_stack
    import rvs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_call_i,
    input  logic                dec_ret_i,
    input  logic [AW-1:0]       dec_nla_i,
    input  logic [AW-1:0]       dec_pred_i,
    input  logic                dec_br_i,
    input  logic [AW-1:0]       dec_fall_i,
    input  logic                exe_mispred_i,
    input  logic [PW-1:0]       exe_ptr_i,
    input  logic [CW-1:0]       exe_cnt_i,
    input  logic                flush_i,
    input  logic                rt_call_i,
    input  logic                rt_ret_i,
    input  logic [AW-1:0]       rt_nla_i,
    output logic                resteer_o,
    output logic [AW-1:0]       resteer_addr_o,
    output logic                pred_copy_o,
    output logic [PW-1:0]       pred_ptr_o,
    output logic [CW-1:0]       pred_cnt_o,
    output logic [DEPTH*AW-1:0] pred_ent_o,
    output logic                tag_vld_o,
    output logic [PW-1:0]       tag_ptr_o,
    output logic [CW-1:0]       tag_cnt_o,
    output logic [AW-1:0]       tag_fall_o
);

    rvs_op_e             spec_op, arch_op;
    logic                ld_state, ld_mem;
    logic [PW-1:0]       spec_ptr, arch_ptr, ld_ptr;
    logic [CW-1:0]       spec_cnt, arch_cnt, ld_cnt;
    logic [DEPTH*AW-1:0] spec_ent, arch_ent;
    logic [AW-1:0]       spec_top;

    assign spec_top = spec_ent[spec_ptr*AW +: AW];
    assign ld_ptr   = flush_i ? arch_ptr : exe_ptr_i;
    assign ld_cnt   = flush_i ? arch_cnt : exe_cnt_i;

    always_comb begin
        if (rt_call_i)
            arch_op = OP_PUSH;
        else if (rt_ret_i)
            arch_op = OP_POP;
        else
            arch_op = OP_NONE;
    end

    rvs_ctrl #(.AW(AW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush_i),
        .mispred_i      (exe_mispred_i),
        .call_i         (dec_call_i),
        .ret_i          (dec_ret_i),
        .pred_i         (dec_pred_i),
        .top_i          (spec_top),
        .empty_i        (spec_cnt == '0),
        .op_o           (spec_op),
        .ld_state_o     (ld_state),
        .ld_mem_o       (ld_mem),
        .resteer_o      (resteer_o),
        .resteer_addr_o (resteer_addr_o),
        .copy_o         (pred_copy_o)
    );

    rvs_lifo #(.AW(AW), .DEPTH(DEPTH)) u_spec (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (spec_op),
        .push_addr_i (dec_nla_i),
        .ld_state_i  (ld_state),
        .ld_mem_i    (ld_mem),
        .ld_ptr_i    (ld_ptr),
        .ld_cnt_i    (ld_cnt),
        .ld_ent_i    (arch_ent),
        .ptr_o       (spec_ptr),
        .cnt_o       (spec_cnt),
        .ent_o       (spec_ent)
    );

    rvs_lifo #(.AW(AW), .DEPTH(DEPTH)) u_arch (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (arch_op),
        .push_addr_i (rt_nla_i),
        .ld_state_i  (1'b0),
        .ld_mem_i    (1'b0),
        .ld_ptr_i    ({PW{1'b0}}),
        .ld_cnt_i    ({CW{1'b0}}),
        .ld_ent_i    ({(DEPTH*AW){1'b0}}),
        .ptr_o       (arch_ptr),
        .cnt_o       (arch_cnt),
        .ent_o       (arch_ent)
    );

    rvs_tag #(.AW(AW), .PW(PW), .CW(CW)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .br_i   (dec_br_i),
        .fall_i (dec_fall_i),
        .ptr_i  (spec_ptr),
        .cnt_i  (spec_cnt),
        .vld_o  (tag_vld_o),
        .ptr_o  (tag_ptr_o),
        .cnt_o  (tag_cnt_o),
        .fall_o (tag_fall_o)
    );

    assign pred_ptr_o = spec_ptr;
    assign pred_cnt_o = spec_cnt;
    assign pred_ent_o = spec_ent;

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dec_call_i,
    input logic                dec_ret_i,
    input logic [AW-1:0]       dec_nla_i,
    input logic                dec_br_i,
    input logic                exe_mispred_i,
    input logic [PW-1:0]       exe_ptr_i,
    input logic [CW-1:0]       exe_cnt_i,
    input logic                flush_i,
    input logic                resteer_o,
    input logic                pred_copy_o,
    input logic [PW-1:0]       pred_ptr_o,
    input logic [CW-1:0]       pred_cnt_o,
    input logic [DEPTH*AW-1:0] pred_ent_o,
    input logic                tag_vld_o,
    input logic [PW-1:0]       tag_ptr_o,
    input logic [PW-1:0]       arch_ptr,
    input logic [CW-1:0]       arch_cnt
);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_cnt_o <= CW'(DEPTH)); // R1

    AST_CALL_WRITES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_call_i && !flush_i && !exe_mispred_i) |=>
            pred_ent_o[pred_ptr_o*AW +: AW] == $past(dec_nla_i)); // R1

    AST_RESTEER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        resteer_o |-> $past(dec_ret_i && !dec_call_i && !flush_i && !exe_mispred_i)); // R2

    AST_COPY_WITH_RESTEER: assert property (@(posedge clk) disable iff (!rst_n)
        resteer_o |-> pred_copy_o); // R3

    AST_EMPTY_NO_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ret_i && !dec_call_i && !flush_i && !exe_mispred_i && pred_cnt_o == '0)
            |=> (!resteer_o && !pred_copy_o)); // R4

    AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_br_i |=> (tag_vld_o && tag_ptr_o == $past(pred_ptr_o))); // R5

    AST_RESTORE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_mispred_i && !flush_i) |=>
            (pred_ptr_o == $past(exe_ptr_i) && pred_cnt_o == $past(exe_cnt_i))); // R6

    AST_FLUSH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (pred_copy_o && !resteer_o && pred_ptr_o == $past(arch_ptr)
                     && pred_cnt_o == $past(arch_cnt))); // R7

endmodule

bind ret_verify_stack rvs_checker #(.AW(AW), .DEPTH(DEPTH)) u_rvs_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dec_call_i    (dec_call_i),
    .dec_ret_i     (dec_ret_i),
    .dec_nla_i     (dec_nla_i),
    .dec_br_i      (dec_br_i),
    .exe_mispred_i (exe_mispred_i),
    .exe_ptr_i     (exe_ptr_i),
    .exe_cnt_i     (exe_cnt_i),
    .flush_i       (flush_i),
    .resteer_o     (resteer_o),
    .pred_copy_o   (pred_copy_o),
    .pred_ptr_o    (pred_ptr_o),
    .pred_cnt_o    (pred_cnt_o),
    .pred_ent_o    (pred_ent_o),
    .tag_vld_o     (tag_vld_o),
    .tag_ptr_o     (tag_ptr_o),
    .arch_ptr      (arch_ptr),
    .arch_cnt      (arch_cnt)
);

// File: tb/ret_verify_stack_test.sv
module ret_verify_stack_test;

    localparam int AW    = 32;
    localparam int DEPTH = 16;
    localparam int PW    = 4;
    localparam int CW    = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst_n;
    logic                dec_call_i, dec_ret_i, dec_br_i, exe_mispred_i, flush_i;
    logic                rt_call_i, rt_ret_i;
    logic [AW-1:0]       dec_nla_i, dec_pred_i, dec_fall_i, rt_nla_i;
    logic [PW-1:0]       exe_ptr_i;
    logic [CW-1:0]       exe_cnt_i;
    logic                resteer_o, pred_copy_o, tag_vld_o;
    logic [AW-1:0]       resteer_addr_o, tag_fall_o;
    logic [PW-1:0]       pred_ptr_o, tag_ptr_o;
    logic [CW-1:0]       pred_cnt_o, tag_cnt_o;
    logic [DEPTH*AW-1:0] pred_ent_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    ret_verify_stack #(.AW(AW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .dec_call_i(dec_call_i), .dec_ret_i(dec_ret_i), .dec_nla_i(dec_nla_i),
        .dec_pred_i(dec_pred_i), .dec_br_i(dec_br_i), .dec_fall_i(dec_fall_i),
        .exe_mispred_i(exe_mispred_i), .exe_ptr_i(exe_ptr_i), .exe_cnt_i(exe_cnt_i),
        .flush_i(flush_i), .rt_call_i(rt_call_i), .rt_ret_i(rt_ret_i), .rt_nla_i(rt_nla_i),
        .resteer_o(resteer_o), .resteer_addr_o(resteer_addr_o), .pred_copy_o(pred_copy_o),
        .pred_ptr_o(pred_ptr_o), .pred_cnt_o(pred_cnt_o), .pred_ent_o(pred_ent_o),
        .tag_vld_o(tag_vld_o), .tag_ptr_o(tag_ptr_o), .tag_cnt_o(tag_cnt_o),
        .tag_fall_o(tag_fall_o)
    );

    function automatic logic [AW-1:0] ca(input int i);
        return 32'h4000_0000 + 32'(i) * 32'd8 + 32'd4;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        dec_call_i = 0; dec_ret_i = 0; dec_br_i = 0; exe_mispred_i = 0; flush_i = 0;
        rt_call_i = 0; rt_ret_i = 0;
        dec_nla_i = '0; dec_pred_i = '0; dec_fall_i = '0; rt_nla_i = '0;
        exe_ptr_i = '0; exe_cnt_i = '0;
    endtask

    // Inputs are set just after a negedge; outputs are read at the next negedge.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic call_op(input logic [AW-1:0] a);
        dec_call_i = 1; dec_nla_i = a; step();
    endtask

    task automatic ret_op(input logic [AW-1:0] p);
        dec_ret_i = 1; dec_pred_i = p; step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // Reset state (R1)
        chk(pred_cnt_o == 0, "R1", "reset cnt", 64'(pred_cnt_o), 0);
        chk(pred_ptr_o == 0, "R1", "reset ptr", 64'(pred_ptr_o), 0);
        chk(!resteer_o && !pred_copy_o && !tag_vld_o, "R1", "reset pulses",
            {61'd0, resteer_o, pred_copy_o, tag_vld_o}, 0);

        // Sweep call depth 0..20, then over-drain with alternating predictions (R1 R2 R3 R4 R9)
        for (int n = 0; n <= 20; n++) begin
            int c0;
            do_reset();
            for (int i = 0; i < n; i++) call_op(ca(i));
            c0 = (n < DEPTH) ? n : DEPTH;
            chk(pred_cnt_o == CW'(c0), "R1", "cnt after calls", 64'(pred_cnt_o), 64'(c0));
            chk(pred_ptr_o == PW'(n % DEPTH), "R9", "ptr after calls", 64'(pred_ptr_o), 64'(n % DEPTH));
            for (int k = 0; k < c0 + 2; k++) begin
                bit           wrong;
                logic [AW-1:0] exp_top;
                wrong   = (k % 2 == 0);
                exp_top = (k < c0) ? ca(n - 1 - k) : 32'h0;
                ret_op(wrong ? (exp_top ^ 32'h10) : exp_top);
                if (k < c0) begin
                    chk(resteer_o == wrong, "R2", "resteer pulse", 64'(resteer_o), 64'(wrong));
                    chk(pred_copy_o == wrong, "R3", "copy pulse", 64'(pred_copy_o), 64'(wrong));
                    chk(pred_ptr_o == PW'((n - k - 1) % DEPTH), "R2", "ptr after pop",
                        64'(pred_ptr_o), 64'((n - k - 1) % DEPTH));
                    if (wrong) begin
                        chk(resteer_addr_o == exp_top, "R9", "resteer address",
                            64'(resteer_addr_o), 64'(exp_top));
                        chk(pred_cnt_o == CW'(c0 - k - 1), "R3", "copied cnt",
                            64'(pred_cnt_o), 64'(c0 - k - 1));
                    end
                end else begin
                    chk(!resteer_o && !pred_copy_o, "R4", "empty no override",
                        {62'd0, resteer_o, pred_copy_o}, 0);
                    chk(pred_cnt_o == 0 && pred_ptr_o == PW'((n - c0) % DEPTH), "R4",
                        "empty state kept", 64'(pred_ptr_o), 64'((n - c0) % DEPTH));
                end
            end
        end

        // Tag capture and execute restore (R5 R6)
        do_reset();
        for (int i = 0; i < 5; i++) call_op(ca(100 + i));
        dec_br_i = 1; dec_fall_i = 32'hF00D_0040; step();
        chk(tag_vld_o && tag_ptr_o == 5 && tag_cnt_o == 5, "R5", "tag ptr/cnt",
            {tag_vld_o, 55'd0, tag_ptr_o, tag_cnt_o[3:0]}, {1'b1, 55'd0, 4'd5, 4'd5});
        chk(tag_fall_o == 32'hF00D_0040, "R5", "tag fall", 64'(tag_fall_o), 64'h F00D_0040);
        step();
        chk(!tag_vld_o, "R5", "tag pulse width", 64'(tag_vld_o), 0);
        for (int i = 0; i < 3; i++) call_op(ca(200 + i));
        ret_op(ca(202));
        exe_mispred_i = 1; exe_ptr_i = 5; exe_cnt_i = 5;
        dec_call_i = 1; dec_nla_i = 32'hDEAD_0000; step();
        chk(pred_ptr_o == 5 && pred_cnt_o == 5, "R6", "restored ptr/cnt",
            {56'd0, pred_ptr_o, pred_cnt_o[3:0]}, {56'd0, 4'd5, 4'd5});
        ret_op(ca(104));
        chk(!resteer_o, "R6", "entry kept, call dropped", 64'(resteer_o), 0);
        ret_op(32'h0);
        chk(resteer_o && resteer_addr_o == ca(103), "R6", "next entry",
            64'(resteer_addr_o), 64'(ca(103)));

        // Architectural reload on flush, outranking restore and decode (R7)
        do_reset();
        call_op(ca(500)); call_op(ca(501));
        for (int i = 0; i < 4; i++) begin rt_call_i = 1; rt_nla_i = ca(300 + i); step(); end
        rt_ret_i = 1; step();
        flush_i = 1; exe_mispred_i = 1; exe_ptr_i = 1; exe_cnt_i = 1;
        dec_ret_i = 1; dec_pred_i = 32'h0; step();
        chk(pred_copy_o && !resteer_o, "R7", "flush copy pulse",
            {62'd0, pred_copy_o, resteer_o}, 64'd2);
        chk(pred_cnt_o == 3 && pred_ptr_o == 3, "R7", "flush state",
            {56'd0, pred_ptr_o, pred_cnt_o[3:0]}, {56'd0, 4'd3, 4'd3});
        step();
        chk(!pred_copy_o, "R7", "copy pulse width", 64'(pred_copy_o), 0);
        ret_op(ca(302));
        chk(!resteer_o, "R7", "arch top match", 64'(resteer_o), 0);
        ret_op(32'h0);
        chk(resteer_o && resteer_addr_o == ca(301), "R7", "arch second entry",
            64'(resteer_addr_o), 64'(ca(301)));

        // Call and return in the same cycle (R8)
        do_reset();
        call_op(ca(400)); call_op(ca(401));
        dec_call_i = 1; dec_nla_i = ca(402); dec_ret_i = 1; dec_pred_i = 32'h0; step();
        chk(!resteer_o && pred_cnt_o == 3, "R8", "return ignored",
            {59'd0, resteer_o, pred_cnt_o[3:0]}, 64'd3);
        ret_op(ca(402));
        chk(!resteer_o, "R8", "call pushed", 64'(resteer_o), 0);
        ret_op(32'h0);
        chk(resteer_o && resteer_addr_o == ca(401), "R8", "older entry",
            64'(resteer_addr_o), 64'(ca(401)));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule